// File: doc/BRIEF.md
# External Management-Interrupt Edge Detector

This block watches an active-low, open-drain request line that devices outside the chip pull low to ask for a system-management interrupt. The line is asynchronous to the PCI clock. The block synchronizes it and looks for a falling edge. When the enable bit is set, it latches that edge into an interrupt request for the CPU. The request stays up until software or the CPU handshake logic pulses the clear input.

The same pin is also driven back by the chip. When an internal serial-interrupt source asks for a management interrupt, the block turns on the pin's low driver, and an external pull-up restores the high level once the driver lets go. The block does not treat its own pull-down as a new external request. After any low level, the detector stays disarmed until the line has been seen high on four consecutive clocks. This keeps a bouncing or slowly rising line from producing a second request.

Top module: `ext_smi_detect`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `smi_out` is 0 and `pin_oe` is 0.
- R2: With `smi_en` = 1 and the detector armed, a high-to-low change of `pin_n_in` sets `smi_out` to 1. This happens on the third rising clock edge after the low level is first present at a sampling edge: two synchronizer stages, then the output register.
- R3: A low level on `pin_n_in` that lasts only one clock period, and is captured by a single sampling edge, is detected like a longer one.
- R4: After any sampled low level, the next falling edge is accepted only if the synchronized line was high on at least four consecutive clocks in between. With only three high clocks, the next low level is ignored.
- R5: A falling edge detected while `smi_en` = 0 leaves `smi_out` unchanged, and the detector still disarms as in R4.
- R6: Once set, `smi_out` stays at 1 until `smi_clr` is high at a rising edge. It reads 0 after that edge, provided no new edge is detected in the same cycle.
- R7: When `smi_clr` and a new enabled detection fall in the same cycle, the detection wins and `smi_out` stays at 1.
- R8: `pin_oe` (1 = drive the pin low) equals the value of `int_smi_req` at the previous rising edge.
- R9: A low level on the pin caused by the block's own drive (`pin_oe` = 1, seen through the two synchronizer stages) never sets `smi_out`. This holds even for a one-cycle internal request.
- R10: A line held low for a long time yields one detection only; `smi_out` does not set again after a clear until the line has gone high per R4 and falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_en | input | 1 | 1 = detected edges raise the interrupt request |
| pin_n_in | input | 1 | Raw level of the shared active-low pin, asynchronous |
| int_smi_req | input | 1 | Internal serial-interrupt source asks for a management interrupt |
| smi_clr | input | 1 | Pulse high to drop the latched request |
| smi_out | output | 1 | Latched management-interrupt request to the CPU, active high |
| pin_oe | output | 1 | 1 = turn on the pin's low driver (open drain) |

## Verification
The hardest case to reach is the drive-back corner. The block must pull its own pin low and then release it, and the delayed low samples still in the synchronizer must not look like an external edge. The high run that follows must also re-arm the detector exactly four clocks later. The stimulus gets there in two ways. Directed sequences pulse `int_smi_req` for one clock and for many clocks. A random phase then mixes internal requests with external low pulses and highs of one to seven clocks. The high-run lengths in that phase sit on both sides of the four-clock re-arm limit, and collisions between clear and detection come up often.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_REARM_RUN   = 4;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/esd_sync.sv
module esd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/esd_drive.sv
module esd_drive #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic int_req,
  output logic oe,
  output logic mask
);
  logic [STAGES-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= int_req;
  end

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_hist
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) hist[0] <= 1'b0;
          else     hist[0] <= oe;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) hist[i] <= 1'b0;
          else     hist[i] <= hist[i-1];
        end
      end
    end
  endgenerate

  // Own drive is visible on the synchronized level for STAGES more cycles.
  assign mask = oe | (|hist);
endmodule

// File: rtl/esd_rearm.sv
module esd_rearm #(
  parameter int unsigned RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic mask,
  output logic hit
);
  localparam int unsigned CW = esd_pkg::cnt_width(RUN);
  localparam logic [CW-1:0] RUN_V = CW'(RUN);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= RUN_V;
    else if (!lvl)           run_cnt <= '0;
    else if (run_cnt != RUN_V) run_cnt <= run_cnt + 1'b1;
  end

  assign hit = !lvl && (run_cnt == RUN_V) && !mask;
endmodule

// File: rtl/esd_latch.sv
module esd_latch (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic en,
  input  logic clr,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)            req <= 1'b0;
    else if (hit && en) req <= 1'b1;
    else if (clr)       req <= 1'b0;
  end
endmodule

// File: rtl/ext_smi_detect.sv
module ext_smi_detect #(
  parameter int unsigned SYNC_STAGES = esd_pkg::DEF_SYNC_STAGES,
  parameter int unsigned REARM_RUN   = esd_pkg::DEF_REARM_RUN
) (
  input  logic clk,
  input  logic rst,
  input  logic smi_en,
  input  logic pin_n_in,
  input  logic int_smi_req,
  input  logic smi_clr,
  output logic smi_out,
  output logic pin_oe
);
  logic lvl_s;
  logic own_mask;
  logic edge_hit;

  esd_drive #(.STAGES(SYNC_STAGES)) u_drive (
    .clk(clk), .rst(rst), .int_req(int_smi_req), .oe(pin_oe), .mask(own_mask)
  );

  esd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_n_in), .sync_out(lvl_s)
  );

  esd_rearm #(.RUN(REARM_RUN)) u_rearm (
    .clk(clk), .rst(rst), .lvl(lvl_s), .mask(own_mask), .hit(edge_hit)
  );

  esd_latch u_latch (
    .clk(clk), .rst(rst), .hit(edge_hit), .en(smi_en), .clr(smi_clr), .req(smi_out)
  );
endmodule

// File: rtl/esd_checker.sv
module esd_checker (
  input logic clk,
  input logic rst,
  input logic smi_en,
  input logic int_smi_req,
  input logic smi_clr,
  input logic smi_out,
  input logic pin_oe,
  input logic edge_hit
);
  p_oe_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pin_oe == $past(int_smi_req)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (smi_out && !smi_clr) |=> smi_out);

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (smi_clr && !edge_hit) |=> !smi_out);

  p_clr_loses_r7: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && smi_en) |=> smi_out);

  p_need_enable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_out) |-> $past(smi_en));

  p_no_self_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_out) |-> !$past(pin_oe));

  p_rearm_gap_r4: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> !edge_hit);
endmodule

bind ext_smi_detect esd_checker u_chk (
  .clk(clk), .rst(rst), .smi_en(smi_en), .int_smi_req(int_smi_req),
  .smi_clr(smi_clr), .smi_out(smi_out), .pin_oe(pin_oe), .edge_hit(edge_hit)
);

// File: tb/ext_smi_detect_tb_top.sv
module ext_smi_detect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smi_en = 1'b0;
  logic ext_n = 1'b1;
  logic int_smi_req = 1'b0;
  logic smi_clr = 1'b0;
  logic smi_out;
  logic pin_oe;
  logic pin_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // open-drain pin with external pull-up
  assign pin_n = ext_n & ~pin_oe;

  ext_smi_detect dut_i (
    .clk(clk), .rst(rst), .smi_en(smi_en), .pin_n_in(pin_n),
    .int_smi_req(int_smi_req), .smi_clr(smi_clr), .smi_out(smi_out), .pin_oe(pin_oe)
  );

  // Reference from requirements: ph[i] = pin level i+1 edges ago, ih likewise for int request
  logic [7:0] ph;
  logic [3:0] ih;
  logic e_smi, e_oe;

  function automatic logic exp_hit(input logic [7:0] p, input logic [3:0] q);
    // low two edges back, four highs before it, no own drive in the last three oe values
    return !p[1] && (&p[5:2]) && !(q[0] | q[1] | q[2]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph <= '1; ih <= '0; e_smi <= 1'b0; e_oe <= 1'b0;
    end else begin
      if (exp_hit(ph, ih) && smi_en) e_smi <= 1'b1;
      else if (smi_clr)              e_smi <= 1'b0;
      e_oe <= int_smi_req;
      ph <= {ph[6:0], pin_n};
      ih <= {ih[2:0], int_smi_req};
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(smi_out, e_smi, "R2 model smi_out");
      chk(pin_oe, e_oe, "R8 model pin_oe");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    chk(smi_out, 1'b0, "R1 smi_out in reset");
    chk(pin_oe, 1'b0, "R1 pin_oe in reset");
    rst = 1'b0;
    step(1);
    chk(smi_out, 1'b0, "R1 smi_out after reset");
    chk(pin_oe, 1'b0, "R1 pin_oe after reset");
    step(6);

    // R2 latency
    smi_en = 1'b1;
    ext_n = 1'b0;
    step(2);
    chk(smi_out, 1'b0, "R2 not yet after two edges");
    step(1);
    chk(smi_out, 1'b1, "R2 set on third edge");
    ext_n = 1'b1;
    step(8);
    chk(smi_out, 1'b1, "R6 held without clear");
    smi_clr = 1'b1; step(1); smi_clr = 1'b0;
    chk(smi_out, 1'b0, "R6 cleared");

    // R3 single-cycle pulse
    step(6);
    ext_n = 1'b0; step(1); ext_n = 1'b1;
    step(2);
    chk(smi_out, 1'b1, "R3 one-cycle pulse detected");
    smi_clr = 1'b1; step(1); smi_clr = 1'b0;
    step(6);

    // R5 disabled edge, then R4 three highs only
    smi_en = 1'b0;
    ext_n = 1'b0; step(1); ext_n = 1'b1;
    step(2);
    chk(smi_out, 1'b0, "R5 disabled edge ignored");
    step(1);
    smi_en = 1'b1;
    ext_n = 1'b0; step(1); ext_n = 1'b1;   // previous low sampled, then exactly 3 highs
    step(6);
    chk(smi_out, 1'b0, "R4 three highs not enough");
    // four highs then low: accepted
    step(1);
    ext_n = 1'b0; step(1); ext_n = 1'b1; step(4);
    ext_n = 1'b0; step(1); ext_n = 1'b1;
    step(2);
    chk(smi_out, 1'b1, "R4 four highs re-arm");
    smi_clr = 1'b1; step(1); smi_clr = 1'b0;

    // R10 long low
    step(6);
    ext_n = 1'b0; step(3);
    chk(smi_out, 1'b1, "R10 first detection");
    smi_clr = 1'b1; step(1); smi_clr = 1'b0;
    step(12);
    chk(smi_out, 1'b0, "R10 no retrigger while low");
    ext_n = 1'b1; step(6);

    // R7 clear collides with detection
    ext_n = 1'b0; step(2);
    smi_clr = 1'b1; step(1); smi_clr = 1'b0;
    chk(smi_out, 1'b1, "R7 detection beats clear");
    ext_n = 1'b1;
    smi_clr = 1'b1; step(1); smi_clr = 1'b0;
    step(6);

    // R8 and R9 own drive
    int_smi_req = 1'b1; step(1); int_smi_req = 1'b0;
    chk(pin_oe, 1'b1, "R8 oe follows request");
    step(1);
    chk(pin_oe, 1'b0, "R8 oe released");
    step(8);
    chk(smi_out, 1'b0, "R9 short own drive not captured");
    int_smi_req = 1'b1; step(10); int_smi_req = 1'b0;
    step(10);
    chk(smi_out, 1'b0, "R9 long own drive not captured");

    // random phase checked against the reference
    model_on = 1;
    for (int i = 0; i < 3000; i++) begin
      int hold;
      hold = 1 + int'($urandom % 7);
      ext_n = ~ext_n;
      for (int j = 0; j < hold; j++) begin
        int_smi_req = (($urandom % 100) < 6);
        smi_clr     = (($urandom % 100) < 12);
        smi_en      = (($urandom % 100) < 85);
        step(1);
      end
    end
    int_smi_req = 1'b0; smi_clr = 1'b0;
    step(4);
    model_on = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule